// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is a register-mapped I2C master that moves a single byte for each software command. Software loads a byte into the data register. It then writes the control register to start the operation. Control bits decide whether a START (or repeated START) comes before the byte, whether a STOP follows it, whether the byte is sent or received, and whether a received byte is acknowledged. The enable bit of the control register stays set while the byte is on the bus and clears by itself when it is done, so software polls it as a busy flag. If the interrupt enable is set, completion also raises a one-cycle interrupt pulse.

The block holds the register file, the divider that paces SCL, and the open-drain drive and sampling of SDA and SCL. Each line has a drive-low output and a sampled input. A sampled SCL that is still low during a high phase makes the controller wait. A write with enable, error and stop set together aborts the transaction: the controller releases the bus with a STOP and sends no byte.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the data register (offset 0) reads 0x00 and the control register (offset 1) reads 0x00. The extended-control register (offset 2) reads 0x0002 and the timing register (offset 4) reads 0x0500. Both line drivers are released and the interrupt is low.
- R2: Control bit 7 (enable) reads 1 from the write that sets it until the byte is finished, then clears by itself. When it clears with bit 6 (interrupt enable) set, the interrupt pulses for one cycle. With bit 6 clear there is no pulse.
- R3: With control bit 1 (start) set, the controller first issues a START, or a repeated START if it already holds the bus. It then sends the data register as an address byte, MSB first. This byte is treated as a write whatever bit 5 holds.
- R4: With control bit 5 clear, the data byte goes out MSB first. Control bit 4 then reads 1 if the slave pulled SDA low on the ninth clock and 0 if it did not.
- R5: With control bit 5 set, the master releases SDA for eight clocks and the data register receives the byte MSB first. On the ninth clock the master drives SDA low only if control bit 4 is set.
- R6: With control bit 0 (stop) set, a STOP follows the ninth clock and both lines end released. Without it, SCL is held low between bytes.
- R7: Writing bits 7, 2 and 0 together issues a STOP without transferring a byte, leaving both lines released.
- R8: Each SCL low phase lasts timing[7:0] + HALF_BIAS system clocks, and so does each high phase. HALF_BIAS defaults to 4.
- R9: Writes to the data or control register while enable reads 1 are ignored.
- R10: SDA changes only while SCL is low, apart from the START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset (0 data, 1 control, 2 extended control, 4 timing) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq | output | 1 | One-cycle completion interrupt |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions check several properties on every cycle. SDA holds still through every SCL high phase of a bit. The lines are released and quiet whenever no transfer is running and the bus is not held. The busy flag rises only from an enabling control write, and the interrupt appears only at the cycle where busy falls with interrupt enable set. A slave model in the bench is needed for the rest: bit order, ACK and NACK in both directions, the START, repeated START and STOP counts, read data, the SCL period against the timing register, and the dropping of register writes made mid-byte. Those come only from its scenarios, which include a sweep of all 256 write bytes.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int          HALF_BIAS = 4,
  parameter logic [15:0] TIM_INIT  = 16'd1280,
  parameter logic [15:0] EXT_INIT  = 16'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  typedef enum logic [3:0] {IDLE, RS1, RS2, RS3, BLO, BHI, STP1, STP2, STP3, TAIL} st_t;

  st_t        st;
  logic [7:0] shreg;
  logic       busy, ie, dir, ackf, errf, stf, spf, rdm, held;
  logic [15:0] ext_q, tim_q;
  logic [8:0] tmr;
  logic [3:0] bitn;
  logic       scl_low, sda_low, irq_q;

  logic [8:0] half;
  logic       tick, stall, txb, hi_phase;

  assign half     = {1'b0, tim_q[7:0]} + 9'(HALF_BIAS);
  assign tick     = (tmr == half - 9'd1);
  assign stall    = (st == BHI || st == RS2) && !scl_in;
  assign txb      = (bitn < 4'd8) ? (rdm ? 1'b1 : shreg[7]) : (rdm ? !ackf : 1'b1);
  assign hi_phase = (st == BHI);
  assign scl_oe   = scl_low;
  assign sda_oe   = sda_low;
  assign irq      = irq_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {8'h00, shreg};
      3'd1:    reg_rdata = {8'h00, busy, ie, dir, ackf, 1'b0, errf, stf, spf};
      3'd2:    reg_rdata = ext_q;
      3'd4:    reg_rdata = tim_q;
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; shreg <= '0; busy <= 1'b0; ie <= 1'b0; dir <= 1'b0; ackf <= 1'b0;
      errf <= 1'b0; stf <= 1'b0; spf <= 1'b0; rdm <= 1'b0; held <= 1'b0;
      ext_q <= EXT_INIT; tim_q <= TIM_INIT; tmr <= '0; bitn <= '0;
      scl_low <= 1'b0; sda_low <= 1'b0; irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: if (!busy) shreg <= reg_wdata[7:0];
          3'd1: if (!busy) begin
            {ie, dir, ackf} <= reg_wdata[6:4];
            {errf, stf, spf} <= reg_wdata[2:0];
            if (reg_wdata[7]) begin
              busy <= 1'b1;
              tmr  <= '0;
              bitn <= '0;
              rdm  <= reg_wdata[5] & !reg_wdata[1];
              if (reg_wdata[2] && reg_wdata[0]) begin
                st <= STP1; scl_low <= 1'b1;
              end else if (reg_wdata[1]) begin
                st <= RS1;
              end else begin
                st <= BLO; scl_low <= 1'b1;
              end
            end
          end
          3'd2: ext_q <= reg_wdata;
          3'd4: tim_q <= reg_wdata;
          default: ;
        endcase
      end
      if (busy && !stall) begin
        tmr <= tick ? 9'd0 : tmr + 9'd1;
        case (st)
          RS1: begin
            sda_low <= 1'b0;
            if (tick) begin st <= RS2; scl_low <= 1'b0; end
          end
          RS2: if (tick) begin st <= RS3; sda_low <= 1'b1; end
          RS3: if (tick) begin st <= BLO; scl_low <= 1'b1; held <= 1'b1; end
          BLO: begin
            sda_low <= !txb;
            if (tick) begin st <= BHI; scl_low <= 1'b0; end
          end
          BHI: if (tick) begin
            scl_low <= 1'b1;
            if (bitn < 4'd8) begin
              shreg <= {shreg[6:0], sda_in};
              bitn  <= bitn + 4'd1;
              st    <= BLO;
            end else begin
              if (!rdm) ackf <= !sda_in;
              st <= spf ? STP1 : TAIL;
            end
          end
          STP1: begin
            sda_low <= 1'b1;
            if (tick) begin st <= STP2; scl_low <= 1'b0; end
          end
          STP2: if (tick) begin st <= STP3; sda_low <= 1'b0; end
          STP3: if (tick) begin st <= IDLE; busy <= 1'b0; irq_q <= ie; held <= 1'b0; end
          TAIL: begin
            sda_low <= 1'b0;
            held    <= 1'b1;
            if (tick) begin st <= IDLE; busy <= 1'b0; irq_q <= ie; end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ie,
  input logic        held,
  input logic        hi_phase,
  input logic        irq,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata
);
  AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(busy) && !busy)); // R2
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie); // R2
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[7])); // R2
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_phase && $past(hi_phase)) |-> $stable(sda_oe)); // R10
  AST_FREE_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !held) |-> (!scl_oe && !sda_oe)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(scl_oe) && $stable(sda_oe))); // R6
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ie(ie), .held(held), .hi_phase(hi_phase),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
  localparam logic [6:0] SADDR = 7'h25;
  localparam int BIAS = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic irq, scl_oe, sda_oe, scl_w, sda_w;
  logic s_sda_low = 0;

  assign scl_w = !scl_oe;
  assign sda_w = !sda_oe && !s_sda_low;

  i2c_byte_master #(.HALF_BIAS(BIAS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, nirq = 0, cyc = 0;
  int nstart = 0, nstop = 0, nrx = 0, per = 0, lastr = 0, bitc = 0;
  logic ps = 1, pd = 1, first = 0, mtx = 0, go_tx = 0, nack_force = 0, ackit;
  logic [7:0] rx = 0, last_rx = 0, txv = 8'h3C;
  logic [7:0] mack_log = 0;

  always @(posedge clk) begin
    cyc++;
    if (irq) nirq++;
  end

  always @(posedge clk) begin
    if (ps && scl_w && pd && !sda_w) begin
      nstart++; bitc = 0; first = 1; mtx = 0; go_tx = 0; s_sda_low <= 0;
    end else if (ps && scl_w && !pd && sda_w) begin
      nstop++; bitc = 0; mtx = 0; go_tx = 0; s_sda_low <= 0;
    end else if (!ps && scl_w) begin
      if (bitc >= 1 && bitc <= 7) per = cyc - lastr;
      lastr = cyc;
      if (bitc < 8) begin
        rx = {rx[6:0], sda_w};
        bitc++;
        if (bitc == 8 && !mtx) begin last_rx = rx; nrx++; end
      end else begin
        if (mtx) begin
          mack_log = {mack_log[6:0], !sda_w};
          txv = txv + 8'd1;
          if (sda_w) mtx = 0;
        end else if (go_tx) mtx = 1;
        go_tx = 0;
        bitc = 0;
      end
    end else if (ps && !scl_w) begin
      if (bitc == 8) begin
        if (!mtx) begin
          ackit = first ? (rx[7:1] == SADDR) : 1'b1;
          if (nack_force) ackit = 0;
          s_sda_low <= ackit;
          go_tx = first && ackit && rx[0];
          first = 0;
        end else s_sda_low <= 0;
      end else if (mtx) s_sda_low <= !txv[7 - bitc];
      else s_sda_low <= 0;
    end
    ps = scl_w; pd = sda_w;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [15:0] v;
    do rd(3'd1, v); while (v[7]);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, input logic [7:0] c);
    wr(3'd0, {8'h00, d});
    wr(3'd1, {8'h00, c});
    wait_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int s0, p0, i0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, v); chk("R1 data", v, 16'h0000);
    rd(3'd1, v); chk("R1 ctrl", v, 16'h0000);
    rd(3'd2, v); chk("R1 ext", v, 16'h0002);
    rd(3'd4, v); chk("R1 timing", v, 16'h0500);
    chk("R1 lines", {scl_oe, sda_oe, irq}, 3'b000);

    wr(3'd4, 16'h0502);
    s0 = nstart; i0 = nirq;
    wr(3'd0, 16'h004A);
    wr(3'd1, 16'h00C2);
    rd(3'd1, v); chk("R2 busy set", v[7], 1'b1);
    wait_done();
    rd(3'd1, v); chk("R2 busy cleared", v[7], 1'b0);
    chk("R4 address ack", v[4], 1'b1);
    chk("R3 start issued", nstart - s0, 1);
    chk("R3 address msb first", last_rx, 8'h4A);
    chk("R2 irq pulse", nirq - i0, 1);

    p0 = nstop;
    for (int b = 0; b < 256; b++) begin
      xfer(8'(b), (b == 255) ? 8'hC1 : 8'hC0);
      rd(3'd1, v);
      chk("R4 data byte", last_rx, b[7:0]);
      chk("R4 ack flag", v[4], 1'b1);
      if (b == 8'h55) chk("R8 scl period 6", per, 2 * (2 + BIAS));
    end
    chk("R6 stop issued", nstop - p0, 1);
    chk("R6 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R10 no stray start", nstart - s0, 1);

    xfer(8'h50, 8'hC2);
    rd(3'd1, v); chk("R4 nack flag", v[4], 1'b0);
    chk("R6 scl held between bytes", scl_oe, 1'b1);
    p0 = nstop;
    xfer(8'h00, 8'h85);
    chk("R7 abort stop", nstop - p0, 1);
    chk("R7 lines released", {scl_oe, sda_oe}, 2'b00);

    i0 = nirq; s0 = nstart; p0 = nstop;
    wr(3'd0, 16'h004A);
    wr(3'd1, 16'h0082);
    wr(3'd0, 16'h0099);
    wr(3'd1, 16'h0085);
    wait_done();
    chk("R2 no irq without enable", nirq - i0, 0);
    rd(3'd0, v); chk("R9 data write ignored", v, 16'h004A);
    rd(3'd1, v); chk("R9 ctrl write ignored", v[2:0], 3'b010);
    chk("R9 no abort stop", nstop - p0, 0);
    chk("R9 single start", nstart - s0, 1);

    xfer(8'h07, 8'hC0);
    s0 = nstart; p0 = nstop;
    xfer(8'h4B, 8'hE2);
    rd(3'd1, v); chk("R3 repeated start ack", v[4], 1'b1);
    chk("R3 repeated start", nstart - s0, 1);
    chk("R3 read address sent", last_rx, 8'h4B);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 8'hF0);
      rd(3'd0, v); chk("R5 read byte", v, {8'h00, 8'h3C + 8'(k)});
    end
    xfer(8'h00, 8'hE1);
    rd(3'd0, v); chk("R5 last read byte", v, 16'h003F);
    chk("R5 master ack pattern", mack_log[3:0], 4'b1110);
    chk("R6 stop after read", nstop - p0, 1);
    chk("R10 start count", nstart - s0, 1);

    wr(3'd4, 16'h0506);
    xfer(8'h4A, 8'hC3);
    chk("R8 scl period 10", per, 2 * (6 + BIAS));
    chk("R6 released after start+stop", {scl_oe, sda_oe}, 2'b00);

    nack_force = 1;
    xfer(8'h4A, 8'hC3);
    rd(3'd1, v); chk("R4 forced nack", v[4], 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule